// File: doc/BRIEF.md
# Multi-Cycle Processor Main Control Sequencer

This block is the main sequencer of a 32-bit load/store processor whose datapath takes several short clock cycles per instruction. It owns a 4-bit state register and, from the current state, the 6-bit opcode and the datapath's equality flag, drives every datapath control point. These are the write enables for the instruction register, program counter, operand latches A and B, the ALU result latch and the memory data latch, the memory read and write strobes, the multiplexer selects, the ALU operation class and the register-file write controls.

Every instruction starts with a shared fetch cycle and a shared decode cycle. Each class then runs its own short tail and returns to fetch. Branch and jump take 3 cycles in total, register-register, OR-immediate and store take 4, and load takes 5. The opcode is consulted only in decode, so the datapath may hold anything on it during the other cycles. The function code of register-register instructions is not decoded here. The sequencer only signals that the ALU should take its operation from it.

Top module: `mc_ctrl`

## Requirements
- R1: Reset is synchronous and active high. It puts the sequencer in fetch (state code 0000). While reset is high every control output is 0.
- R2: The fetch state has code 0000. In fetch, ir_we=1, mem_rd=1, pc_we=1, pc_src=0 (ALU result), alu_a_sel=0 (PC) and alu_b_sel=1 (constant 4), alu_op=0 (add). Fetch always moves to decode, and ir_we is never 1 outside fetch.
- R3: Decode has code 0001 and asserts a_we, b_we and aluout_we, with alu_a_sel=0 and alu_b_sel=3 (sign-extended immediate shifted left by 2), add. Its successor depends on the opcode: 000000 register-register, 001101 OR-immediate, 100011 load, 101011 store, 000100 branch-if-equal, 000010 jump.
- R4: Branch-if-equal takes 3 cycles. Its one execute cycle sets alu_a_sel=1 (A), alu_b_sel=0 (B), alu_op=1 (subtract) and pc_src=1 (ALU result latch). In that cycle pc_we equals the equality flag. The next state is fetch.
- R5: Jump takes 3 cycles. Its one execute cycle sets pc_src=2 (jump target) and pc_we=1, then goes to fetch.
- R6: Load takes 5 cycles. The address cycle sets alu_a_sel=1, alu_b_sel=2 (sign-extended immediate), add and aluout_we. The read cycle sets mem_rd, addr_sel=1 (ALU result latch) and mdr_we. The write-back cycle sets rf_we, rf_dst=0 (rt) and rf_src=1 (memory data).
- R7: Store takes 4 cycles. The address cycle is the same as the load address cycle. It is followed by a write cycle with mem_wr=1 and addr_sel=1, and then by fetch.
- R8: Register-register takes 4 cycles. The execute cycle sets alu_a_sel=1, alu_b_sel=0, alu_op=2 (function field) and aluout_we. The write-back cycle sets rf_we, rf_dst=1 (rd) and rf_src=0.
- R9: OR-immediate takes 4 cycles. The execute cycle sets alu_a_sel=1, alu_b_sel=4 (zero-extended immediate), alu_op=3 (OR) and aluout_we. The write-back cycle sets rf_we, rf_dst=0 and rf_src=0.
- R10: Any other opcode sends decode straight back to fetch, so the instruction takes 2 cycles and drives no enable beyond those of fetch and decode.
- R11: After decode the opcode input has no effect. Outputs and state sequence depend only on the class latched at decode.
- R12: Any control output not named for a state in R2 to R9 is 0 there, and mem_rd and mem_wr are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| eq_flag | input | 1 | Datapath equality result (A equals B) |
| cur_state | output | 4 | Current state code |
| ir_we | output | 1 | Instruction register write enable |
| pc_we | output | 1 | Program counter write enable |
| pc_src | output | 2 | PC source: 0 ALU, 1 ALU latch, 2 jump target |
| a_we | output | 1 | Operand A latch enable |
| b_we | output | 1 | Operand B latch enable |
| aluout_we | output | 1 | ALU result latch enable |
| mdr_we | output | 1 | Memory data latch enable |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU latch |
| alu_a_sel | output | 1 | ALU first operand: 0 PC, 1 A |
| alu_b_sel | output | 3 | ALU second operand: 0 B, 1 four, 2 sext, 3 sext<<2, 4 zext |
| alu_op | output | 2 | ALU class: 0 add, 1 sub, 2 function field, 3 OR |
| rf_we | output | 1 | Register file write enable |
| rf_dst | output | 1 | Destination: 0 rt, 1 rd |
| rf_src | output | 1 | Write data: 0 ALU latch, 1 memory data |

## Verification
In the branch execute cycle the compare and the conditional PC update fall together. The equality flag is flipped every cycle in the surrounding states and set for each branch in turn, so a branch with the flag high and one with it low are both seen. The bench model predicts pc_we from the flag live in that same cycle. Reset can also fall in the middle of a load's memory read. The bench raises it there and expects every control to drop in that same cycle and fetch to follow, while a scrambled opcode is driven during every non-decode cycle to show it is ignored.

// File: rtl/mc_ctrl.sv
module mc_ctrl #(
  parameter int OPW = 6,
  parameter int STW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [OPW-1:0] opcode,
  input  logic           eq_flag,
  output logic [STW-1:0] cur_state,
  output logic           ir_we,
  output logic           pc_we,
  output logic [1:0]     pc_src,
  output logic           a_we,
  output logic           b_we,
  output logic           aluout_we,
  output logic           mdr_we,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           addr_sel,
  output logic           alu_a_sel,
  output logic [2:0]     alu_b_sel,
  output logic [1:0]     alu_op,
  output logic           rf_we,
  output logic           rf_dst,
  output logic           rf_src
);
  localparam logic [OPW-1:0] OP_RR  = 6'b000000;
  localparam logic [OPW-1:0] OP_JMP = 6'b000010;
  localparam logic [OPW-1:0] OP_BEQ = 6'b000100;
  localparam logic [OPW-1:0] OP_ORI = 6'b001101;
  localparam logic [OPW-1:0] OP_LD  = 6'b100011;
  localparam logic [OPW-1:0] OP_ST  = 6'b101011;

  typedef enum logic [STW-1:0] {
    S_FETCH = 4'd0,  S_DEC   = 4'd1,  S_LDADR = 4'd2,  S_LDRD = 4'd3,
    S_LDWB  = 4'd4,  S_STADR = 4'd5,  S_STWR  = 4'd6,  S_RREX = 4'd7,
    S_RRWB  = 4'd8,  S_ORIEX = 4'd9,  S_ORIWB = 4'd10, S_BEQ  = 4'd11,
    S_JMP   = 4'd12
  } st_t;

  st_t state_q, state_d;

  assign cur_state = state_q;

  always_ff @(posedge clk) begin
    if (rst) state_q <= S_FETCH;
    else     state_q <= state_d;
  end

  always_comb begin
    state_d = S_FETCH;
    case (state_q)
      S_FETCH: state_d = S_DEC;
      S_DEC: begin
        case (opcode)
          OP_RR:   state_d = S_RREX;
          OP_ORI:  state_d = S_ORIEX;
          OP_LD:   state_d = S_LDADR;
          OP_ST:   state_d = S_STADR;
          OP_BEQ:  state_d = S_BEQ;
          OP_JMP:  state_d = S_JMP;
          default: state_d = S_FETCH;
        endcase
      end
      S_LDADR: state_d = S_LDRD;
      S_LDRD:  state_d = S_LDWB;
      S_STADR: state_d = S_STWR;
      S_RREX:  state_d = S_RRWB;
      S_ORIEX: state_d = S_ORIWB;
      default: state_d = S_FETCH;
    endcase
  end

  always_comb begin
    {ir_we, pc_we, pc_src, a_we, b_we, aluout_we, mdr_we, mem_rd, mem_wr,
     addr_sel, alu_a_sel, alu_b_sel, alu_op, rf_we, rf_dst, rf_src} = '0;
    if (!rst) begin
      case (state_q)
        S_FETCH: begin
          ir_we = 1'b1; mem_rd = 1'b1; pc_we = 1'b1;
          alu_b_sel = 3'd1;
        end
        S_DEC: begin
          a_we = 1'b1; b_we = 1'b1; aluout_we = 1'b1;
          alu_b_sel = 3'd3;
        end
        S_LDADR, S_STADR: begin
          alu_a_sel = 1'b1; alu_b_sel = 3'd2; aluout_we = 1'b1;
        end
        S_LDRD: begin
          mem_rd = 1'b1; addr_sel = 1'b1; mdr_we = 1'b1;
        end
        S_LDWB: begin
          rf_we = 1'b1; rf_src = 1'b1;
        end
        S_STWR: begin
          mem_wr = 1'b1; addr_sel = 1'b1;
        end
        S_RREX: begin
          alu_a_sel = 1'b1; alu_op = 2'd2; aluout_we = 1'b1;
        end
        S_RRWB: begin
          rf_we = 1'b1; rf_dst = 1'b1;
        end
        S_ORIEX: begin
          alu_a_sel = 1'b1; alu_b_sel = 3'd4; alu_op = 2'd3; aluout_we = 1'b1;
        end
        S_ORIWB: rf_we = 1'b1;
        S_BEQ: begin
          alu_a_sel = 1'b1; alu_op = 2'd1; pc_src = 2'd1; pc_we = eq_flag;
        end
        S_JMP: begin
          pc_src = 2'd2; pc_we = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mc_ctrl_chk.sv
module mc_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       eq_flag,
  input logic [3:0] cur_state,
  input logic       ir_we,
  input logic       pc_we,
  input logic [1:0] pc_src,
  input logic       a_we,
  input logic       b_we,
  input logic       aluout_we,
  input logic       mdr_we,
  input logic       mem_rd,
  input logic       mem_wr,
  input logic       rf_we,
  input logic       rf_src
);
  assert_rst_quiet_R1: assert property (@(posedge clk)
    rst |-> !(ir_we || pc_we || a_we || b_we || aluout_we || mdr_we || mem_rd || mem_wr || rf_we));

  assert_ir_in_fetch_R2: assert property (@(posedge clk) disable iff (rst)
    ir_we |-> cur_state == 4'd0);

  assert_fetch_to_dec_R3: assert property (@(posedge clk) disable iff (rst)
    cur_state == 4'd0 |=> cur_state == 4'd1);

  assert_beq_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (pc_src == 2'd1 && !eq_flag) |-> !pc_we);

  assert_jump_return_R5: assert property (@(posedge clk) disable iff (rst)
    (pc_src == 2'd2 && pc_we) |=> cur_state == 4'd0);

  assert_load_wb_R6: assert property (@(posedge clk) disable iff (rst)
    mdr_we |=> (rf_we && rf_src));

  assert_store_return_R7: assert property (@(posedge clk) disable iff (rst)
    mem_wr |=> cur_state == 4'd0);

  assert_mem_excl_R12: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));
endmodule

bind mc_ctrl mc_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .eq_flag(eq_flag), .cur_state(cur_state),
  .ir_we(ir_we), .pc_we(pc_we), .pc_src(pc_src), .a_we(a_we), .b_we(b_we),
  .aluout_we(aluout_we), .mdr_we(mdr_we), .mem_rd(mem_rd), .mem_wr(mem_wr),
  .rf_we(rf_we), .rf_src(rf_src)
);

// File: tb/mc_ctrl_tb.sv
module mc_ctrl_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst = 1'b1;
  logic [5:0] opcode = 6'd0;
  logic       eq_flag = 1'b0;
  logic [3:0] cur_state;
  logic       ir_we, pc_we, a_we, b_we, aluout_we, mdr_we, mem_rd, mem_wr;
  logic       addr_sel, alu_a_sel, rf_we, rf_dst, rf_src;
  logic [1:0] pc_src, alu_op;
  logic [2:0] alu_b_sel;

  mc_ctrl u_dut (
    .clk(clk), .rst(rst), .opcode(opcode), .eq_flag(eq_flag), .cur_state(cur_state),
    .ir_we(ir_we), .pc_we(pc_we), .pc_src(pc_src), .a_we(a_we), .b_we(b_we),
    .aluout_we(aluout_we), .mdr_we(mdr_we), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .addr_sel(addr_sel), .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
    .alu_op(alu_op), .rf_we(rf_we), .rf_dst(rf_dst), .rf_src(rf_src)
  );

  int checks = 0;
  int fails = 0;
  int phase = 0;
  int cls = 0;
  int junk_i = 0;
  bit unk_ret = 0;
  bit done = 0;

  // classes: 0 reg-reg, 1 or-imm, 2 load, 3 store, 4 branch, 5 jump, 6 unknown
  function automatic int classify(logic [5:0] op);
    case (op)
      6'b000000: return 0;
      6'b001101: return 1;
      6'b100011: return 2;
      6'b101011: return 3;
      6'b000100: return 4;
      6'b000010: return 5;
      default:   return 6;
    endcase
  endfunction

  function automatic int last_phase(int c);
    if (c == 4 || c == 5) return 2;
    if (c == 2) return 4;
    return 3;
  endfunction

  function automatic logic [19:0] expect_vec(int ph, int c, logic eq, logic r);
    logic ir = 0, pcw = 0, aw = 0, bw = 0, ow = 0, mw = 0, mr = 0, mwr = 0;
    logic asl = 0, aas = 0, rw = 0, rd = 0, rs = 0;
    logic [1:0] pcs = 0, op = 0;
    logic [2:0] bs = 0;
    if (!r) begin
      if (ph == 0) begin ir = 1; mr = 1; pcw = 1; bs = 1; end
      else if (ph == 1) begin aw = 1; bw = 1; ow = 1; bs = 3; end
      else begin
        case (c)
          0: if (ph == 2) begin aas = 1; op = 2; ow = 1; end
             else begin rw = 1; rd = 1; end
          1: if (ph == 2) begin aas = 1; bs = 4; op = 3; ow = 1; end
             else rw = 1;
          2: if (ph == 2) begin aas = 1; bs = 2; ow = 1; end
             else if (ph == 3) begin mr = 1; asl = 1; mw = 1; end
             else begin rw = 1; rs = 1; end
          3: if (ph == 2) begin aas = 1; bs = 2; ow = 1; end
             else begin mwr = 1; asl = 1; end
          4: begin aas = 1; op = 1; pcs = 1; pcw = eq; end
          5: begin pcs = 2; pcw = 1; end
          default: ;
        endcase
      end
    end
    return {ir, pcw, pcs, aw, bw, ow, mw, mr, mwr, asl, aas, bs, op, rw, rd, rs};
  endfunction

  function automatic string tag_of(int ph, int c, logic r, bit u);
    if (r) return "R1";
    if (ph == 0) return u ? "R10" : "R2";
    if (ph == 1) return "R3";
    case (c)
      0: return "R8/R11";
      1: return "R9/R11";
      2: return "R6/R11";
      3: return "R7/R11";
      4: return "R4/R11";
      default: return "R5/R11";
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin phase = 0; unk_ret = 0; end
    else if (phase == 0) begin phase = 1; unk_ret = 0; end
    else if (phase == 1) begin
      cls = classify(opcode);
      if (cls == 6) begin phase = 0; unk_ret = 1; end
      else phase = 2;
    end
    else if (phase == last_phase(cls)) phase = 0;
    else phase = phase + 1;
  end

  task automatic step();
    logic [19:0] act, exp;
    string t;
    @(negedge clk);
    act = {ir_we, pc_we, pc_src, a_we, b_we, aluout_we, mdr_we, mem_rd, mem_wr,
           addr_sel, alu_a_sel, alu_b_sel, alu_op, rf_we, rf_dst, rf_src};
    exp = expect_vec(phase, cls, eq_flag, rst);
    t = tag_of(phase, cls, rst, unk_ret);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s phase %0d: controls %b expected %b", t, phase, act, exp);
    end
    if (phase == 0) begin
      checks++;
      if (cur_state !== 4'd0) begin
        fails++;
        $display("FAIL %s fetch state code: got %b expected 0000", t, cur_state);
      end
    end
    checks++;
    if (mem_rd === 1'b1 && mem_wr === 1'b1) begin
      fails++;
      $display("FAIL R12 strobes: rd %b wr %b expected not both 1", mem_rd, mem_wr);
    end
  endtask

  // R11: outside decode the opcode is scrambled and the flag toggled
  task automatic drive_junk();
    logic [5:0] pool [4] = '{6'b100011, 6'b000010, 6'b101011, 6'b000100};
    opcode = pool[junk_i % 4];
    junk_i++;
    eq_flag = ~eq_flag;
  endtask

  logic [5:0] prog_op [12] = '{6'b000000, 6'b001101, 6'b100011, 6'b101011,
                               6'b000100, 6'b000100, 6'b000010, 6'b111111,
                               6'b000001, 6'b100011, 6'b000100, 6'b000000};
  logic       prog_eq [12] = '{0, 1, 0, 1, 1, 0, 0, 1, 0, 1, 0, 1};

  initial begin
    repeat (3) step();
    rst = 1'b0;
    for (int i = 0; i < 12; i++) begin
      do begin step(); drive_junk(); end while (phase != 1);
      opcode = prog_op[i];
      eq_flag = prog_eq[i];
    end
    do begin step(); drive_junk(); end while (phase != 1);
    opcode = 6'b100011;
    do begin step(); if (phase != 3) drive_junk(); end while (phase != 3);
    rst = 1'b1;
    step();
    rst = 1'b0;
    for (int k = 0; k < 10; k++) begin
      step();
      if (phase == 1) begin opcode = 6'b001101; eq_flag = 1'b1; end
      else drive_junk();
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule